// File: doc/BRIEF.md
# Four-Sequencer Triggered Sample Controller

This block manages four independent sample sequencers that share one trigger input. When a trigger pulse arrives, every sequencer that is switched on and whose four-bit trigger-source code equals 5 draws a fresh value from a shared pseudo-random source. It pushes that value into its private 16-entry FIFO and flags its raw interrupt bit. Each sequencer has its own interrupt line, gated by a mask bit. If a sequencer's FIFO is full, the new value is discarded and the sequencer's overflow flag is raised.

Software reaches the block through a plain register port. A write strobe carries an address and data. A read strobe returns data combinationally in the same cycle. A read of a FIFO address also pops that FIFO at the next clock edge. The pseudo-random source is a 32-bit multiply-add generator that stands in for a real converter. Sequencers that accept the same trigger advance it one after another, lowest index first.

Top module: `adc_seq_ctrl`

## Requirements
- R1: An active-low reset clears the enable, mask, trigger-select, raw status and overflow registers and empties every FIFO. It also reloads the generator state with 0x12345678. After reset all interrupt lines are 0, and every register read returns 0.
- R2: The enable register (address 0x00) stores only the low 4 bits of a write, one bit per sequencer, and any combination is allowed. Writing 0xF3 reads back 0x3.
- R3: On a trigger, sequencer n accepts only if enable bit n is 1 and bits [4n+3:4n] of the trigger-select register (address 0x10) equal 5. Any other sequencer writes nothing to its FIFO and leaves its raw bit unchanged.
- R4: Each accepting sequencer advances the generator as state = state*314159 + 1, with 32-bit wraparound. Sequencers advance it in index order 0 to 3 within one trigger.
- R5: The value a sequencer pushes is 0x200 plus bits [18:16] of the generator state after its own advance.
- R6: After an accepting trigger, bit n of the raw status register (address 0x04) is 1 on the clock edge that samples the trigger.
- R7: Interrupt line n equals the AND of raw bit n and bit n of the mask register (address 0x08). Each of the four lines is independent of the others.
- R8: Reading address 0x20+4n returns the oldest entry of FIFO n and removes it. Entries come out in the order they were pushed, and each FIFO holds 16 entries.
- R9: A push into a full FIFO sets bit n of the overflow register (address 0x0C). The value is discarded, and the stored entries and pointers are unchanged.
- R10: Writing 1 to bit n of address 0x04 clears raw bit n. Writing 1 to bit n of address 0x0C clears overflow bit n. Bits written as 0 keep their value. A set from a trigger in the same cycle takes priority over the clear.
- R11: Reading an empty FIFO returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| trig | input | 1 | Trigger pulse, sampled on each rising edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; pops a FIFO when the address is a FIFO address |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as rd_en |
| irq | output | 4 | Per-sequencer masked interrupt lines |

## Verification
A trigger that is high before a rising edge updates the raw bits, the overflow bits, the FIFO contents and the interrupt lines at that same edge. A register write also takes effect at the edge that samples it. Read data is combinational while rd_en is high, and the pop lands on the following edge. The bench changes inputs only on falling edges and samples outputs 1 ns after a falling edge. That sample point is one full edge after the stimulus that produced the result, and it comes before the next rising edge can change the result again.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the four-sequencer sample controller.
// Assumes byte addresses on an 8-bit register port and 32-bit data.
package adc_seq_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int NOISE_W     = 32;
    localparam int SEL_W       = 4;
    localparam logic [SEL_W-1:0]   TRIG_CODE  = 4'd5;
    localparam logic [NOISE_W-1:0] NOISE_MUL  = 32'd314159;
    localparam logic [NOISE_W-1:0] NOISE_SEED = 32'h1234_5678;
    localparam int SAMPLE_BASE = 'h200;

    localparam logic [ADDR_W-1:0] ADDR_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_RAW  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 8'h08;
    localparam logic [ADDR_W-1:0] ADDR_OVF  = 8'h0C;
    localparam logic [ADDR_W-1:0] ADDR_SEL  = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_FIFO = 8'h20;
    localparam int                FIFO_STRIDE = 4;
endpackage

// File: rtl/adc_noise_chain.sv
// Combinational multiply-add generator chain: one stage per sequencer.
// A stage advances the state only when its sequencer accepts the trigger.
// Lower indices advance first. Assumes SAMPLE_W is wide enough for base+7.
module adc_noise_chain
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ  = 4,
    parameter int SAMPLE_W = 12
) (
    input  logic [NOISE_W-1:0]                 state_in,
    input  logic [NUM_SEQ-1:0]                 accept,
    output logic [NOISE_W-1:0]                 state_out,
    output logic [NUM_SEQ-1:0][SAMPLE_W-1:0]   sample
);
    logic [NOISE_W-1:0] stage [0:NUM_SEQ];

    assign stage[0] = state_in;

    genvar g;
    generate
        for (g = 0; g < NUM_SEQ; g++) begin : g_stage
            logic [NOISE_W-1:0] advanced;
            // advance the state by one multiply-add step
            assign advanced     = stage[g] * NOISE_MUL + NOISE_W'(1);
            // pass the state through unless this sequencer accepts
            assign stage[g+1]   = accept[g] ? advanced : stage[g];
            // sample derived from the state after this sequencer's advance
            assign sample[g]    = SAMPLE_W'(SAMPLE_BASE) + SAMPLE_W'(advanced[18:16]);
        end
    endgenerate

    assign state_out = stage[NUM_SEQ];
endmodule

// File: rtl/adc_sample_fifo.sv
// Per-sequencer sample FIFO. A push into a full FIFO is dropped and
// reported through ovf_evt. A pop of an empty FIFO is ignored.
// dout shows the oldest entry, or 0 when the FIFO is empty.
// Assumes DEPTH is a power of two.
module adc_sample_fifo #(
    parameter int DEPTH    = 16,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] dout,
    output logic                full,
    output logic                ovf_evt
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]    head_q, tail_q;
    logic [PTR_W:0]      count_q;
    logic                empty, push_ok, pop_ok;

    assign empty   = (count_q == '0);
    assign full    = (count_q == (PTR_W+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovf_evt = push && full;
    assign dout    = empty ? '0 : mem[tail_q];

    // storage write on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[head_q] <= din;
        end
    end

    // pointer and occupancy upkeep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) head_q <= head_q + PTR_W'(1);
            if (pop_ok)  tail_q <= tail_q + PTR_W'(1);
            count_q <= count_q + (PTR_W+1)'(push_ok) - (PTR_W+1)'(pop_ok);
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Four-sequencer triggered sample controller: register file, trigger
// filter, generator state, per-sequencer FIFOs and masked interrupts.
// Assumes single-cycle rd_en/wr_en strobes; read data is combinational.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int SAMPLE_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_SEQ-1:0] irq
);
    localparam int SEL_BITS = SEL_W * NUM_SEQ;

    logic [NUM_SEQ-1:0]  en_q, mask_q, raw_q, ovf_q;
    logic [SEL_BITS-1:0] sel_q;
    logic [NOISE_W-1:0]  noise_q, noise_next;
    logic [NUM_SEQ-1:0]  accept, pop, ovf_evt, full;
    logic [NUM_SEQ-1:0][SAMPLE_W-1:0] sample, fifo_dout;
    logic                wr_raw, wr_ovf;

    assign wr_raw = wr_en && (addr == ADDR_RAW);
    assign wr_ovf = wr_en && (addr == ADDR_OVF);

    genvar g;
    generate
        for (g = 0; g < NUM_SEQ; g++) begin : g_seq
            // trigger filter: enabled and source code matches
            assign accept[g] = trig && en_q[g] && (sel_q[g*SEL_W +: SEL_W] == TRIG_CODE);
            // a read at this sequencer's FIFO address pops it
            assign pop[g]    = rd_en && (addr == ADDR_W'(ADDR_FIFO + FIFO_STRIDE * g));

            adc_sample_fifo #(
                .DEPTH    (FIFO_DEPTH),
                .SAMPLE_W (SAMPLE_W)
            ) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .push    (accept[g]),
                .din     (sample[g]),
                .pop     (pop[g]),
                .dout    (fifo_dout[g]),
                .full    (full[g]),
                .ovf_evt (ovf_evt[g])
            );
        end
    endgenerate

    adc_noise_chain #(
        .NUM_SEQ  (NUM_SEQ),
        .SAMPLE_W (SAMPLE_W)
    ) u_noise (
        .state_in  (noise_q),
        .accept    (accept),
        .state_out (noise_next),
        .sample    (sample)
    );

    // configuration registers written by the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
            sel_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_EN)   en_q   <= wdata[NUM_SEQ-1:0];
            if (addr == ADDR_MASK) mask_q <= wdata[NUM_SEQ-1:0];
            if (addr == ADDR_SEL)  sel_q  <= wdata[SEL_BITS-1:0];
        end
    end

    // status flags: write-one-to-clear, with a same-cycle set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            ovf_q <= '0;
        end else begin
            raw_q <= (raw_q & ~(wr_raw ? wdata[NUM_SEQ-1:0] : '0)) | accept;
            ovf_q <= (ovf_q & ~(wr_ovf ? wdata[NUM_SEQ-1:0] : '0)) | ovf_evt;
        end
    end

    // generator state advances once per accepting sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) noise_q <= NOISE_SEED;
        else        noise_q <= noise_next;
    end

    // combinational read-data multiplexer
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_EN:   rdata[NUM_SEQ-1:0]  = en_q;
                ADDR_RAW:  rdata[NUM_SEQ-1:0]  = raw_q;
                ADDR_MASK: rdata[NUM_SEQ-1:0]  = mask_q;
                ADDR_OVF:  rdata[NUM_SEQ-1:0]  = ovf_q;
                ADDR_SEL:  rdata[SEL_BITS-1:0] = sel_q;
                default: begin
                    for (int n = 0; n < NUM_SEQ; n++) begin
                        if (pop[n]) rdata[SAMPLE_W-1:0] = fifo_dout[n];
                    end
                end
            endcase
        end
    end

    // per-line masked interrupt outputs
    assign irq = raw_q & mask_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Assertion checker for adc_seq_ctrl, attached through bind.
// Observes the ports and the status/config registers.
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int NUM_SEQ = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      trig,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         addr,
    input logic [DATA_W-1:0]         wdata,
    input logic [NUM_SEQ-1:0]        irq,
    input logic [NUM_SEQ-1:0]        en_q,
    input logic [NUM_SEQ-1:0]        mask_q,
    input logic [NUM_SEQ-1:0]        raw_q,
    input logic [NUM_SEQ-1:0]        ovf_q,
    input logic [SEL_W*NUM_SEQ-1:0]  sel_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && mask_q == '0 && raw_q == '0 && ovf_q == '0));

    // R2
    enable_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_EN) |=> (en_q == $past(wdata[NUM_SEQ-1:0])));

    // R7
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~raw_q) == '0);

    // R10
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !(wr_en && addr == ADDR_RAW)) |=> $stable(raw_q));

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !(wr_en && addr == ADDR_OVF)) |=> $stable(ovf_q));

    genvar g;
    generate
        for (g = 0; g < NUM_SEQ; g++) begin : g_chk
            // R6
            raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (trig && en_q[g] && sel_q[g*SEL_W +: SEL_W] == TRIG_CODE) |=> raw_q[g]);
        end
    endgenerate
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NUM_SEQ(NUM_SEQ)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .irq    (irq),
    .en_q   (en_q),
    .mask_q (mask_q),
    .raw_q  (raw_q),
    .ovf_q  (ovf_q),
    .sel_q  (sel_q)
);

// File: tb/test_adc_seq_ctrl.sv
// Self-checking bench: vector table of enable/select patterns, then
// directed tests for reset, FIFO ordering, overflow and clears.
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] nmodel = 32'h1234_5678;
    logic [31:0] d;
    logic [7:0]  ev;
    logic [15:0] sv;
    logic [3:0]  exp_raw;
    logic [11:0] expq [16];

    // each entry: {enable write value[7:0], trigger-select[15:0]}
    localparam logic [23:0] VEC [7] = '{
        24'h01_0005, 24'h0F_5555, 24'h0F_5050, 24'h0A_5555,
        24'h05_0505, 24'h0F_6432, 24'hF3_5555
    };
    localparam logic [3:0] MASK = 4'hB;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step_noise();
        nmodel = nmodel * 32'd314159 + 32'd1;
    endtask

    function automatic logic [31:0] cur_sample();
        return 32'h200 + {29'd0, nmodel[18:16]};
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #1 check("R1 irq", {28'd0, irq}, 32'h0);
        bus_rd(8'h00, d); check("R1 enable", d, 0);
        bus_rd(8'h04, d); check("R1 raw", d, 0);
        bus_rd(8'h08, d); check("R1 mask", d, 0);
        bus_rd(8'h0C, d); check("R1 overflow", d, 0);
        bus_rd(8'h10, d); check("R1 select", d, 0);
        bus_rd(8'h20, d); check("R1 fifo", d, 0);

        // vector table walk: R2 R3 R4 R5 R6 R7 R11
        for (int v = 0; v < 7; v++) begin
            ev = VEC[v][23:16];
            sv = VEC[v][15:0];
            bus_wr(8'h00, {24'd0, ev});
            bus_wr(8'h10, {16'd0, sv});
            bus_wr(8'h04, 32'hF);
            bus_wr(8'h08, {28'd0, MASK});
            for (int k = 0; k < 4; k++)
                exp_raw[k] = ev[k] && (sv[4*k +: 4] == 4'd5);
            pulse();
            #1 check("R7 irq", {28'd0, irq}, {28'd0, exp_raw & MASK});
            bus_rd(8'h04, d); check("R6 raw", d, {28'd0, exp_raw});
            bus_rd(8'h00, d); check("R2 enable", d, {28'd0, ev[3:0]});
            for (int k = 0; k < 4; k++) begin
                bus_rd(8'h20 + 8'(4*k), d);
                if (exp_raw[k]) begin
                    step_noise();
                    check("R4 R5 sample", d, cur_sample());
                end else begin
                    check("R3 skipped", d, 0);
                end
            end
            for (int k = 0; k < 4; k++) begin
                bus_rd(8'h20 + 8'(4*k), d); check("R11 empty", d, 0);
            end
        end

        // overflow and ordering: R8 R9
        bus_wr(8'h04, 32'hF);
        bus_wr(8'h00, 32'h1);
        bus_wr(8'h10, 32'h5);
        for (int i = 0; i < 17; i++) begin
            pulse();
            step_noise();
            if (i < 16) expq[i] = cur_sample()[11:0];
        end
        bus_rd(8'h0C, d); check("R9 overflow set", d, 32'h1);
        for (int i = 0; i < 16; i++) begin
            bus_rd(8'h20, d); check("R8 order", d, {20'd0, expq[i]});
        end
        bus_rd(8'h20, d); check("R9 dropped", d, 0);

        // clears: R10
        bus_wr(8'h0C, 32'h0);
        bus_rd(8'h0C, d); check("R10 zero write keeps", d, 32'h1);
        bus_wr(8'h0C, 32'h1);
        bus_rd(8'h0C, d); check("R10 overflow clear", d, 0);
        bus_wr(8'h04, 32'h1);
        bus_rd(8'h04, d); check("R10 raw clear", d, 0);
        bus_wr(8'h04, 32'h1);
        trig = 1'b1; wr_en = 1'b1; addr = 8'h04; wdata = 32'h1;
        @(negedge clk);
        trig = 1'b0; wr_en = 1'b0;
        step_noise();
        bus_rd(8'h04, d); check("R10 set wins", d, 32'h1);
        bus_rd(8'h20, d); check("R5 sample", d, cur_sample());

        // R1: reset mid-run and reseed
        bus_wr(8'h08, 32'hF);
        pulse();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        nmodel = 32'h1234_5678;
        #1 check("R1 irq after reset", {28'd0, irq}, 0);
        bus_rd(8'h08, d); check("R1 mask after reset", d, 0);
        bus_rd(8'h20, d); check("R1 fifo after reset", d, 0);
        bus_wr(8'h00, 32'h1);
        bus_wr(8'h10, 32'h5);
        pulse();
        step_noise();
        bus_rd(8'h20, d); check("R4 reseed", d, cur_sample());

        finish_run();
    end
endmodule